// File: doc/BRIEF.md
# High-Frequency Clock Source Enable Sequencer

This block decides on every clock cycle whether three high-frequency clock sources are enabled: a crystal oscillator, a PLL that multiplies the crystal, and an internal RC oscillator. It combines several kinds of hardware request into one hardware enable per source. These are wakeup events, sleep-entry events, a radio timer interrupt, forced-on system clock selections, and write-one set and clear pulses. A software override can then replace the enable of each source.

The PLL depends on the crystal. It is enabled only after a programmable settle counter shows the crystal is stable, and it drops in the same cycle as the crystal enable. Its active-low reset is released one cycle after its enable. The oscillators themselves, lock detection, trimming and calibration are outside the block.

Top module: `hfclk_enable_seq`

## Requirements
- R1: While `rstN` is low, `xoEn`, `pllEn`, `pllRstN`, `rcEn` and `xoStable` are all 0.
- R2: Without an override, `xoEn` and `rcEn` stay 0 in any cycle that follows a cycle in which `railReady` was 0.
- R3: A `wakeEvt` pulse requests the crystal if any of these holds: `xoPwrUpEn` is 1, `pllPwrUpEn` is 1, `mcuClkSel` equals 2, or `rootSelFast` is 0. It requests the PLL if `pllPwrUpEn` is 1 or `rootSelFast` is 0. It always requests the RC oscillator.
- R4: While `mcuClkSel` equals 2 or `rootSelFast` is 0, the crystal is kept on one edge later, whatever clear or sleep events occur. While `rootSelFast` is 0, the PLL is also kept requested.
- R5: The source bit index is 0 for the crystal, 1 for the PLL and 2 for the RC oscillator. A `setReq` bit latches a request for its source and a `clrReq` bit removes it. If both arrive in the same cycle, the clear wins. The enable follows on the second rising edge after the pulse cycle.
- R6: A PLL set pulse (`setReq[1]`) also requests the crystal.
- R7: A `radioTimerIrq` pulse requests both the crystal and the PLL when `timerAutoOn` is 1. It has no effect when `timerAutoOn` is 0.
- R8: `xoStable` rises `settleCycles` cycles after `xoEn` rises. It is 0 whenever `xoEn` is 0.
- R9: Without an override, `pllEn` is 1 only while `xoEn` and `xoStable` are both 1. It rises on the edge after the crystal first reads stable and falls on the same edge as `xoEn`. `pllRstN` rises one edge after `pllEn`.
- R10: On `sleepEvt`, each source whose `sleepOffCfg` bit is set loses its request. The crystal also loses its request when `dcdcOffCfg` and `ldoOffCfg` are both 1; either bit alone has no effect.
- R11: A clear of the RC oscillator is ignored while `mcuClkSel` equals 0, because the system clock then runs from the RC oscillator.
- R12: When `ovrEn[i]` is 1, the enable of source i takes `ovrVal[i]` on the next edge. The PLL override also drives `pllRstN` from `pllRstNOvrVal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wakeEvt | input | 1 | Wakeup event pulse |
| sleepEvt | input | 1 | Sleep-entry event pulse |
| radioTimerIrq | input | 1 | Radio timer interrupt pulse |
| timerAutoOn | input | 1 | Timer interrupt turns on crystal and PLL |
| mcuClkSel | input | SEL_W | MCU clock select (2 = crystal, 0 = RC) |
| rootSelFast | input | 1 | Root clock select; 0 = root from PLL |
| railReady | input | 1 | DC-DC or LDO rail is up |
| xoPwrUpEn | input | 1 | Crystal on at wakeup |
| pllPwrUpEn | input | 1 | PLL on at wakeup |
| setReq | input | 3 | Write-one set pulses per source |
| clrReq | input | 3 | Write-one clear pulses per source |
| sleepOffCfg | input | 3 | Per-source auto-off at sleep entry |
| dcdcOffCfg | input | 1 | DC-DC converter off at sleep |
| ldoOffCfg | input | 1 | LDO off at sleep |
| ovrEn | input | 3 | Per-source override enable |
| ovrVal | input | 3 | Per-source override enable value |
| pllRstNOvrVal | input | 1 | Override value for the PLL reset |
| settleCycles | input | CNT_W | Crystal settle time in cycles |
| xoEn | output | 1 | Crystal enable |
| pllEn | output | 1 | PLL enable |
| pllRstN | output | 1 | PLL active-low reset |
| rcEn | output | 1 | RC oscillator enable |
| xoStable | output | 1 | Crystal settle readback |

## Verification
The assertions check on every cycle the properties that hold between neighbouring cycles. These are the rail gating of both oscillators, the forced-on crystal selections, the PLL's dependence on a stable, enabled crystal, the release of its reset only after its enable, and the next-edge effect of the RC override. Other behaviour depends on the order of events, and only the bench scenarios can show it. This covers clear winning over set, wakeup decoding, timer auto-on being ignored, the exact settle delay, the per-source sleep auto-off with its two-bit rail condition, and RC clears refused while the system runs on it.

// File: rtl/hfclk_seq_pkg.sv
package hfclk_seq_pkg;
  localparam int NUM_SRC = 3;
  localparam int SRC_XO  = 0;
  localparam int SRC_PLL = 1;
  localparam int SRC_RC  = 2;

  // control -> datapath strobes
  typedef struct packed {
    logic [NUM_SRC-1:0] enD;           // per-source next enable (override applied)
    logic               pllOvrEn;      // PLL under software control
    logic               pllRstNOvrVal; // software value for PLL reset
  } seqStrobe_t;
endpackage

// File: rtl/hfclk_seq_ctrl.sv
module hfclk_seq_ctrl
  import hfclk_seq_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter logic [SEL_W-1:0] SEL_CODE_XO = SEL_W'(2),
  parameter logic [SEL_W-1:0] SEL_CODE_RC = SEL_W'(0)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wakeEvt,
  input  logic               sleepEvt,
  input  logic               radioTimerIrq,
  input  logic               timerAutoOn,
  input  logic [SEL_W-1:0]   mcuClkSel,
  input  logic               rootSelFast,
  input  logic               railReady,
  input  logic               xoPwrUpEn,
  input  logic               pllPwrUpEn,
  input  logic [NUM_SRC-1:0] setReq,
  input  logic [NUM_SRC-1:0] clrReq,
  input  logic [NUM_SRC-1:0] sleepOffCfg,
  input  logic               dcdcOffCfg,
  input  logic               ldoOffCfg,
  input  logic [NUM_SRC-1:0] ovrEn,
  input  logic [NUM_SRC-1:0] ovrVal,
  input  logic               pllRstNOvrVal,
  output seqStrobe_t         strobe
);
  logic rootOnPll, sysOnXo, sysOnRc, irqAutoOn, railsOffAtSleep;
  logic [NUM_SRC-1:0] setTerm, clrTerm, reqQ, hwOn;

  assign rootOnPll       = ~rootSelFast;
  assign sysOnXo         = (mcuClkSel == SEL_CODE_XO);
  assign sysOnRc         = (mcuClkSel == SEL_CODE_RC);
  assign irqAutoOn       = radioTimerIrq & timerAutoOn;
  assign railsOffAtSleep = dcdcOffCfg & ldoOffCfg;

  // merge every request path per source
  always_comb begin
    setTerm[SRC_XO]  = setReq[SRC_XO] | setReq[SRC_PLL] | irqAutoOn |
                       (wakeEvt & (xoPwrUpEn | pllPwrUpEn | sysOnXo | rootOnPll));
    setTerm[SRC_PLL] = setReq[SRC_PLL] | irqAutoOn |
                       (wakeEvt & (pllPwrUpEn | rootOnPll));
    setTerm[SRC_RC]  = setReq[SRC_RC] | wakeEvt;

    clrTerm[SRC_XO]  = clrReq[SRC_XO] |
                       (sleepEvt & (sleepOffCfg[SRC_XO] | railsOffAtSleep));
    clrTerm[SRC_PLL] = clrReq[SRC_PLL] | (sleepEvt & sleepOffCfg[SRC_PLL]);
    clrTerm[SRC_RC]  = (clrReq[SRC_RC] & ~sysOnRc) |
                       (sleepEvt & sleepOffCfg[SRC_RC]);
  end

  // per-source request latch, clear dominant
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ <= '0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (clrTerm[i])      reqQ[i] <= 1'b0;
        else if (setTerm[i]) reqQ[i] <= 1'b1;
      end
    end
  end

  // hardware-computed wish (PLL before its crystal gating)
  always_comb begin
    hwOn[SRC_XO]  = railReady & (reqQ[SRC_XO] | sysOnXo | rootOnPll);
    hwOn[SRC_PLL] = reqQ[SRC_PLL] | rootOnPll;
    hwOn[SRC_RC]  = railReady & reqQ[SRC_RC];
  end

  // software override per source
  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_ovr
      assign strobe.enD[g] = ovrEn[g] ? ovrVal[g] : hwOn[g];
    end
  endgenerate

  assign strobe.pllOvrEn      = ovrEn[SRC_PLL];
  assign strobe.pllRstNOvrVal = pllRstNOvrVal;
endmodule

// File: rtl/hfclk_seq_dp.sv
module hfclk_seq_dp
  import hfclk_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [CNT_W-1:0] settleCycles,
  output logic             xoEn,
  output logic             pllEn,
  output logic             pllRstN,
  output logic             rcEn,
  output logic             xoStable
);
  logic [CNT_W-1:0] settleCnt;
  logic pllHw, pllEnD, pllRstND;

  assign xoStable = xoEn & (settleCnt >= settleCycles);

  // PLL needs a stable crystal that also stays on at this edge
  assign pllHw    = strobe.enD[SRC_PLL] & xoStable & strobe.enD[SRC_XO];
  assign pllEnD   = strobe.pllOvrEn ? strobe.enD[SRC_PLL] : pllHw;
  assign pllRstND = strobe.pllOvrEn ? strobe.pllRstNOvrVal : (pllEn & pllHw);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
    end else if (!xoEn) begin
      settleCnt <= '0;
    end else if (settleCnt < settleCycles) begin
      settleCnt <= settleCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xoEn    <= 1'b0;
      rcEn    <= 1'b0;
      pllEn   <= 1'b0;
      pllRstN <= 1'b0;
    end else begin
      xoEn    <= strobe.enD[SRC_XO];
      rcEn    <= strobe.enD[SRC_RC];
      pllEn   <= pllEnD;
      pllRstN <= pllRstND;
    end
  end
endmodule

// File: rtl/hfclk_enable_seq.sv
module hfclk_enable_seq
  import hfclk_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wakeEvt,
  input  logic             sleepEvt,
  input  logic             radioTimerIrq,
  input  logic             timerAutoOn,
  input  logic [SEL_W-1:0] mcuClkSel,
  input  logic             rootSelFast,
  input  logic             railReady,
  input  logic             xoPwrUpEn,
  input  logic             pllPwrUpEn,
  input  logic [2:0]       setReq,
  input  logic [2:0]       clrReq,
  input  logic [2:0]       sleepOffCfg,
  input  logic             dcdcOffCfg,
  input  logic             ldoOffCfg,
  input  logic [2:0]       ovrEn,
  input  logic [2:0]       ovrVal,
  input  logic             pllRstNOvrVal,
  input  logic [CNT_W-1:0] settleCycles,
  output logic             xoEn,
  output logic             pllEn,
  output logic             pllRstN,
  output logic             rcEn,
  output logic             xoStable
);
  seqStrobe_t strobe;

  hfclk_seq_ctrl #(
    .SEL_W(SEL_W),
    .SEL_CODE_XO(SEL_W'(2)),
    .SEL_CODE_RC(SEL_W'(0))
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .wakeEvt(wakeEvt), .sleepEvt(sleepEvt),
    .radioTimerIrq(radioTimerIrq), .timerAutoOn(timerAutoOn),
    .mcuClkSel(mcuClkSel), .rootSelFast(rootSelFast), .railReady(railReady),
    .xoPwrUpEn(xoPwrUpEn), .pllPwrUpEn(pllPwrUpEn), .setReq(setReq),
    .clrReq(clrReq), .sleepOffCfg(sleepOffCfg), .dcdcOffCfg(dcdcOffCfg),
    .ldoOffCfg(ldoOffCfg), .ovrEn(ovrEn), .ovrVal(ovrVal),
    .pllRstNOvrVal(pllRstNOvrVal), .strobe(strobe)
  );

  hfclk_seq_dp #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .settleCycles(settleCycles),
    .xoEn(xoEn), .pllEn(pllEn), .pllRstN(pllRstN), .rcEn(rcEn),
    .xoStable(xoStable)
  );
endmodule

// File: rtl/hfclk_seq_checker.sv
module hfclk_seq_checker #(
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic [SEL_W-1:0] mcuClkSel,
  input logic             rootSelFast,
  input logic             railReady,
  input logic [2:0]       ovrEn,
  input logic [2:0]       ovrVal,
  input logic             xoEn,
  input logic             pllEn,
  input logic             pllRstN,
  input logic             rcEn,
  input logic             xoStable
);
  p_rail_xo_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!railReady && !ovrEn[0]) |=> !xoEn);

  p_rail_rc_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!railReady && !ovrEn[2]) |=> !rcEn);

  p_forced_xo_r4: assert property (@(posedge clk) disable iff (!rstN)
    (railReady && !ovrEn[0] && (mcuClkSel == SEL_W'(2) || !rootSelFast)) |=> xoEn);

  p_stable_needs_en_r8: assert property (@(posedge clk) disable iff (!rstN)
    xoStable |-> xoEn);

  p_pll_needs_xo_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pllEn && !$past(ovrEn[1])) |-> (xoEn && xoStable));

  p_rst_after_en_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(pllRstN) && !$past(ovrEn[1])) |-> $past(pllEn));

  p_rc_override_r12: assert property (@(posedge clk) disable iff (!rstN)
    ovrEn[2] |=> (rcEn == $past(ovrVal[2])));
endmodule

bind hfclk_enable_seq hfclk_seq_checker #(.SEL_W(SEL_W)) i_chk (
  .clk(clk), .rstN(rstN), .mcuClkSel(mcuClkSel), .rootSelFast(rootSelFast),
  .railReady(railReady), .ovrEn(ovrEn), .ovrVal(ovrVal), .xoEn(xoEn),
  .pllEn(pllEn), .pllRstN(pllRstN), .rcEn(rcEn), .xoStable(xoStable)
);

// File: tb/test_hfclk_enable_seq.sv
module test_hfclk_enable_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wakeEvt = 0, sleepEvt = 0, radioTimerIrq = 0, timerAutoOn = 0;
  logic [1:0] mcuClkSel = 2'd1;
  logic rootSelFast = 1, railReady = 0, xoPwrUpEn = 0, pllPwrUpEn = 0;
  logic [2:0] setReq = 0, clrReq = 0, sleepOffCfg = 0, ovrEn = 0, ovrVal = 0;
  logic dcdcOffCfg = 0, ldoOffCfg = 0, pllRstNOvrVal = 0;
  logic [15:0] settleCycles = 16'd3;
  logic xoEn, pllEn, pllRstN, rcEn, xoStable;

  int checks = 0, errors = 0;
  bit finished = 0;
  string curTag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  hfclk_enable_seq i_hfclk_enable_seq (
    .clk(clk), .rstN(rstN), .wakeEvt(wakeEvt), .sleepEvt(sleepEvt),
    .radioTimerIrq(radioTimerIrq), .timerAutoOn(timerAutoOn),
    .mcuClkSel(mcuClkSel), .rootSelFast(rootSelFast), .railReady(railReady),
    .xoPwrUpEn(xoPwrUpEn), .pllPwrUpEn(pllPwrUpEn), .setReq(setReq),
    .clrReq(clrReq), .sleepOffCfg(sleepOffCfg), .dcdcOffCfg(dcdcOffCfg),
    .ldoOffCfg(ldoOffCfg), .ovrEn(ovrEn), .ovrVal(ovrVal),
    .pllRstNOvrVal(pllRstNOvrVal), .settleCycles(settleCycles),
    .xoEn(xoEn), .pllEn(pllEn), .pllRstN(pllRstN), .rcEn(rcEn),
    .xoStable(xoStable)
  );

  // behavioural reference: request bits, outputs, settle count
  bit mReqXo, mReqPll, mReqRc, mXoEn, mPllEn, mRstN, mRcEn;
  int mCnt;

  function automatic bit modelStable();
    return mXoEn && (mCnt >= int'(settleCycles));
  endfunction

  always @(posedge clk or negedge rstN) begin : refModel
    bit rootPll, onXoSel, onRcSel, stableNow, xoNext, rcNext, pllWish, pllNext, rstNext;
    if (!rstN) begin
      mReqXo = 0; mReqPll = 0; mReqRc = 0;
      mXoEn = 0; mPllEn = 0; mRstN = 0; mRcEn = 0; mCnt = 0;
    end else begin
      rootPll   = (rootSelFast == 1'b0);
      onXoSel   = (mcuClkSel == 2'd2);
      onRcSel   = (mcuClkSel == 2'd0);
      stableNow = modelStable();
      xoNext  = ovrEn[0] ? ovrVal[0] : (railReady && (mReqXo || onXoSel || rootPll));
      rcNext  = ovrEn[2] ? ovrVal[2] : (railReady && mReqRc);
      pllWish = ovrEn[1] ? ovrVal[1] : (mReqPll || rootPll);
      if (ovrEn[1]) begin
        pllNext = ovrVal[1];
        rstNext = pllRstNOvrVal;
      end else begin
        pllNext = pllWish && stableNow && xoNext;
        rstNext = mPllEn && pllNext;
      end
      if (!mXoEn) mCnt = 0;
      else if (mCnt < int'(settleCycles)) mCnt++;
      mXoEn = xoNext; mRcEn = rcNext; mPllEn = pllNext; mRstN = rstNext;
      // requests: clear beats set
      if (clrReq[0] || (sleepEvt && (sleepOffCfg[0] || (dcdcOffCfg && ldoOffCfg)))) mReqXo = 0;
      else if (setReq[0] || setReq[1] || (radioTimerIrq && timerAutoOn) ||
               (wakeEvt && (xoPwrUpEn || pllPwrUpEn || onXoSel || rootPll))) mReqXo = 1;
      if (clrReq[1] || (sleepEvt && sleepOffCfg[1])) mReqPll = 0;
      else if (setReq[1] || (radioTimerIrq && timerAutoOn) ||
               (wakeEvt && (pllPwrUpEn || rootPll))) mReqPll = 1;
      if ((clrReq[2] && !onRcSel) || (sleepEvt && sleepOffCfg[2])) mReqRc = 0;
      else if (setReq[2] || wakeEvt) mReqRc = 1;
    end
  end

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareModel();
    chk(curTag, "xoEn", xoEn, mXoEn);
    chk(curTag, "pllEn", pllEn, mPllEn);
    chk(curTag, "pllRstN", pllRstN, mRstN);
    chk(curTag, "rcEn", rcEn, mRcEn);
    chk(curTag, "xoStable", xoStable, modelStable());
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
      compareModel();
    end
  endtask

  task automatic pulseSet(input logic [2:0] v);
    setReq = v; tick(); setReq = 0;
  endtask

  task automatic pulseClr(input logic [2:0] v);
    clrReq = v; tick(); clrReq = 0;
  endtask

  task automatic cleanup();
    mcuClkSel = 2'd1; rootSelFast = 1;
    pulseClr(3'b111); tick(3);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stimulus
    @(negedge clk);
    // R1: reset state
    curTag = "R1";
    tick(2);
    chk("R1", "xoEn", xoEn, 0); chk("R1", "pllRstN", pllRstN, 0);
    chk("R1", "rcEn", rcEn, 0); chk("R1", "pllEn", pllEn, 0);
    rstN = 1;
    tick(2);

    // R2: rail gating, then R3 wake decoding through the rail
    curTag = "R2";
    xoPwrUpEn = 1; wakeEvt = 1; tick(); wakeEvt = 0; xoPwrUpEn = 0;
    tick(3);
    chk("R2", "xoEn without rail", xoEn, 0);
    chk("R2", "rcEn without rail", rcEn, 0);
    railReady = 1; tick();
    chk("R2", "xoEn after rail", xoEn, 1);
    chk("R3", "rcEn on wake", rcEn, 1);
    cleanup();

    curTag = "R3";
    pllPwrUpEn = 1; wakeEvt = 1; tick(); wakeEvt = 0; pllPwrUpEn = 0;
    tick();
    chk("R3", "xoEn via pll power-up bit", xoEn, 1);
    tick(6);
    chk("R3", "pllEn via pll power-up bit", pllEn, 1);
    cleanup();

    // R8: settle delay of 3
    curTag = "R8";
    pulseSet(3'b001);
    tick(); chk("R8", "xoEn", xoEn, 1); chk("R8", "xoStable early", xoStable, 0);
    tick(2); chk("R8", "xoStable early", xoStable, 0);
    tick(); chk("R8", "xoStable at settle", xoStable, 1);
    cleanup();
    chk("R8", "xoStable after off", xoStable, 0);

    // R6 / R9: PLL set pulls the crystal, then PLL chain timing
    curTag = "R9";
    pulseSet(3'b010);
    tick(); chk("R6", "xoEn from pll set", xoEn, 1);
    tick(3); chk("R9", "pllEn before stable", pllEn, 0);
    tick(); chk("R9", "pllEn", pllEn, 1); chk("R9", "pllRstN held", pllRstN, 0);
    tick(); chk("R9", "pllRstN released", pllRstN, 1);
    pulseClr(3'b001);
    tick(); chk("R9", "xoEn off", xoEn, 0); chk("R9", "pllEn with xo", pllEn, 0);
    chk("R9", "pllRstN with xo", pllRstN, 0);
    cleanup();

    // R5: clear wins, set latency
    curTag = "R5";
    setReq = 3'b001; clrReq = 3'b001; tick(); setReq = 0; clrReq = 0;
    tick(3); chk("R5", "xoEn clear wins", xoEn, 0);
    pulseSet(3'b001);
    tick(); chk("R5", "xoEn after set", xoEn, 1);
    cleanup();

    // R7: timer auto-on
    curTag = "R7";
    radioTimerIrq = 1; tick(); radioTimerIrq = 0;
    tick(3); chk("R7", "xoEn ignored irq", xoEn, 0); chk("R7", "pllEn ignored irq", pllEn, 0);
    timerAutoOn = 1; radioTimerIrq = 1; tick(); radioTimerIrq = 0; timerAutoOn = 0;
    tick(8); chk("R7", "pllEn auto", pllEn, 1); chk("R7", "xoEn auto", xoEn, 1);
    cleanup();

    // R10: sleep auto-off
    curTag = "R10";
    pulseSet(3'b111); tick(8);
    sleepOffCfg = 3'b010; sleepEvt = 1; tick(); sleepEvt = 0;
    tick(); chk("R10", "pllEn off", pllEn, 0); chk("R10", "xoEn kept", xoEn, 1);
    chk("R10", "rcEn kept", rcEn, 1);
    sleepOffCfg = 3'b100; sleepEvt = 1; tick(); sleepEvt = 0;
    tick(); chk("R10", "rcEn off", rcEn, 0);
    sleepOffCfg = 0; dcdcOffCfg = 1; sleepEvt = 1; tick(); sleepEvt = 0;
    tick(); chk("R10", "xoEn one rail bit", xoEn, 1);
    ldoOffCfg = 1; sleepEvt = 1; tick(); sleepEvt = 0;
    tick(); chk("R10", "xoEn both rail bits", xoEn, 0);
    dcdcOffCfg = 0; ldoOffCfg = 0;
    cleanup();

    // R11: RC clear refused while system on RC
    curTag = "R11";
    pulseSet(3'b100); tick(); chk("R11", "rcEn on", rcEn, 1);
    mcuClkSel = 2'd0; pulseClr(3'b100); tick(2);
    chk("R11", "rcEn kept", rcEn, 1);
    mcuClkSel = 2'd1; pulseClr(3'b100); tick();
    chk("R11", "rcEn cleared", rcEn, 0);
    cleanup();

    // R4: forced-on selections
    curTag = "R4";
    mcuClkSel = 2'd2; tick(); chk("R4", "xoEn forced", xoEn, 1);
    sleepOffCfg = 3'b001; clrReq = 3'b001; sleepEvt = 1; tick();
    clrReq = 0; sleepEvt = 0; sleepOffCfg = 0;
    tick(); chk("R4", "xoEn still forced", xoEn, 1);
    mcuClkSel = 2'd1; tick(2); chk("R4", "xoEn released", xoEn, 0);
    rootSelFast = 0; tick(6);
    chk("R4", "xoEn root", xoEn, 1); chk("R4", "pllEn root", pllEn, 1);
    rootSelFast = 1; tick(2);
    chk("R4", "pllEn released", pllEn, 0); chk("R4", "xoEn released", xoEn, 0);
    cleanup();

    // R12: overrides
    curTag = "R12";
    railReady = 0;
    ovrEn = 3'b001; ovrVal = 3'b001; tick();
    chk("R12", "xoEn override", xoEn, 1);
    ovrEn = 3'b011; ovrVal = 3'b011; pllRstNOvrVal = 1; tick();
    chk("R12", "pllEn override", pllEn, 1); chk("R12", "pllRstN override", pllRstN, 1);
    ovrVal = 3'b000; tick();
    chk("R12", "xoEn override off", xoEn, 0); chk("R12", "pllEn override off", pllEn, 0);
    chk("R12", "pllRstN override value", pllRstN, 1);
    ovrEn = 3'b100; ovrVal = 3'b100; pllRstNOvrVal = 0; tick();
    chk("R12", "rcEn override", rcEn, 1);
    ovrEn = 0; ovrVal = 0; tick(2);
    chk("R12", "rcEn released", rcEn, 0); chk("R12", "pllRstN released", pllRstN, 0);
    railReady = 1; tick(2);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule